// File: doc/BRIEF.md
# Sensor Command Port with Control Registers

This block is the host-facing command front end of an image sensor core. A host drives a mode 0 SPI link (clock idle low, data captured on the rising edge, most significant bit first) with an active-low select. Each byte the host clocks in is answered by one byte on MISO. The first byte of a select window is a command code. The codes cover register reads and writes, with the register index carried in the low five bits, popping a pixel from the image FIFO, reading a status byte, starting a scan, and a soft reset. Several commands can be chained inside one select window. A register write is the exception: once a write opens, every later byte in that window is write data.

The SPI pins are brought into the system clock domain by synchronizers and edge detection. The clock rate must therefore be several times the SCK rate. The eighteen control registers, the status composition and the chip-enable key check all live in the system clock domain. The core stays in reset until the low five bits of the last register hold the enable key. A soft reset pulses the core reset without touching the registers.

Top module: `fp_spi_cmd_core`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 except register 0x10, which reads 0x40. core_rst is 1, det_en and intr_en are 0, and spi_miso is 0.
- R2: Bytes are exchanged full-duplex, MSB first, with MOSI sampled on the SCK rising edge and MISO changed after the falling edge. The first byte returned in any select window is 0x00.
- R3: Code 0x20+N with N from 0x00 to 0x11 returns register N on the next byte exchange.
- R4: Code 0x40+N with N from 0x00 to 0x11 makes every later byte of the window write data. The bytes go to registers N, N+1 and so on up to 0x11, and any bytes after that are dropped. MISO returns 0x00 while writing. Codes 0x52 to 0x5F start a write stream that stores nothing.
- R5: Code 0x01 pops one entry from the pixel FIFO (a one-cycle pix_pop) and returns it on the next exchange. If pix_valid is low, no pop occurs and 0x00 is returned.
- R6: Code 0x02 pulses scan_start for one clock when the chip is enabled, and does nothing when it is not.
- R7: Code 0x03 returns the status byte on the next exchange. Bit 0 is pix_valid, bit 1 is scan_busy, bit 2 is finger_hit, bit 3 is the chip-enabled flag, and bits 7:4 are 0.
- R8: Code 0xC0 raises core_rst for exactly one clock while the chip is enabled, and keeps every register value.
- R9: The chip is enabled only while bits [4:0] of register 0x11 equal 0x15. Otherwise core_rst is held at 1.
- R10: det_en follows bit 5 of register 0x10, and intr_en follows bit 6 of register 0x11.
- R11: Any other code (including 0x32 to 0x3F) changes nothing and returns 0x00 on the next exchange.
- R12: Raising spi_csn returns the parser to waiting for a command. An open write stream and any pending response are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_csn | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| pix_data | input | 8 | Head entry of the pixel FIFO |
| pix_valid | input | 1 | Pixel FIFO holds data |
| pix_pop | output | 1 | One-clock pop of the pixel FIFO |
| scan_busy | input | 1 | Scan in progress, shown in status |
| finger_hit | input | 1 | Finger detected, shown in status |
| scan_start | output | 1 | One-clock scan start strobe |
| core_rst | output | 1 | Reset to the sensor core |
| det_en | output | 1 | Detection mode enable |
| intr_en | output | 1 | Detect interrupt enable |

## Verification
The assertions check the following on every cycle. A pop never happens without FIFO data. At most one strobe or write fires per clock. Write addresses stay inside the register range. A written byte lands in its register. A dropped select forces the parser back to command wait with no pending response. A missing key or a soft reset drives core_rst on the next clock. Other behaviour depends on byte sequences, and only the bench scenarios can show it: chained commands, write streams running past the last register, responses arriving one exchange late, and registers surviving a soft reset.

// File: rtl/fp_spi_pkg.sv
package fp_spi_pkg;
  localparam logic [7:0] OP_PIX  = 8'h01;
  localparam logic [7:0] OP_SCAN = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h03;
  localparam logic [7:0] OP_SRST = 8'hC0;
  localparam logic [2:0] GRP_RD  = 3'b001;
  localparam logic [2:0] GRP_WR  = 3'b010;

  typedef enum logic [0:0] {
    PS_CMD   = 1'b0,
    PS_WRITE = 1'b1
  } parse_state_t;
endpackage

// File: rtl/fp_spi_sync.sv
module fp_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_start,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_q, csn_q, mosi_q;
  logic sck_d, csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck_i};
      csn_q  <= {csn_q[STAGES-2:0], csn_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      sck_d  <= sck_q[STAGES-1];
      csn_d  <= csn_q[STAGES-1];
    end
  end

  assign cs_act   = ~csn_q[STAGES-1];
  assign cs_start = ~csn_q[STAGES-1] & csn_d;
  assign sck_rise = cs_act & sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = cs_act & ~sck_q[STAGES-1] & sck_d;
  assign mosi_s   = mosi_q[STAGES-1];

  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sck_rise && sck_fall));
endmodule

// File: rtl/fp_spi_byte_xfer.sv
module fp_spi_byte_xfer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_act,
  input  logic          cs_start,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          miso
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    rx_valid <= 1'b0;
    if (rst) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rx_byte <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      tx_sh   <= '0;
    end else begin
      if (cs_start) tx_sh <= tx_byte;
      if (sck_rise) begin
        rx_sh <= {rx_sh[DW-2:0], mosi_s};
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh[DW-2:0], mosi_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (sck_fall) begin
        if (bit_cnt == '0) tx_sh <= tx_byte;
        else               tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[DW-1];

  a_r2_byte_in_window: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(cs_act));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);
endmodule

// File: rtl/fp_reg_bank.sv
module fp_reg_bank #(
  parameter int         DW       = 8,
  parameter int         NUM_REGS = 18,
  parameter int         MODE_REG = 16,
  parameter int         KEY_REG  = 17,
  parameter logic [7:0] MODE_RST = 8'h40,
  parameter int         DET_BIT  = 5,
  parameter int         INTR_BIT = 6,
  parameter int         KEY_W    = 5,
  localparam int        AW       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             det_bit,
  output logic             intr_bit,
  output logic [KEY_W-1:0] key_field
);
  logic [DW-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        mem[i] <= (i == MODE_REG) ? DW'(MODE_RST) : '0;
    end else if (wr_en && (int'(wr_addr) < NUM_REGS)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data   = (int'(rd_addr) < NUM_REGS) ? mem[rd_addr] : '0;
  assign det_bit   = mem[MODE_REG][DET_BIT];
  assign intr_bit  = mem[KEY_REG][INTR_BIT];
  assign key_field = mem[KEY_REG][KEY_W-1:0];

  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/fp_cmd_parser.sv
module fp_cmd_parser
  import fp_spi_pkg::*;
#(
  parameter int  DW       = 8,
  parameter int  NUM_REGS = 18,
  localparam int AW       = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_valid,
  input  logic [DW-1:0] status_byte,
  input  logic          chip_en,
  output logic [DW-1:0] tx_byte,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          pix_pop,
  output logic          scan_start,
  output logic          soft_rst
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(NUM_REGS - 1);

  parse_state_t  state;
  logic [AW-1:0] wr_ptr;
  logic          wr_live;
  logic [4:0]    idx;
  logic          idx_ok;

  assign idx     = rx_byte[4:0];
  assign idx_ok  = int'(idx) < NUM_REGS;
  assign rd_addr = AW'(idx);

  always_ff @(posedge clk) begin
    wr_en      <= 1'b0;
    pix_pop    <= 1'b0;
    scan_start <= 1'b0;
    soft_rst   <= 1'b0;
    if (rst) begin
      state   <= PS_CMD;
      tx_byte <= '0;
      wr_ptr  <= '0;
      wr_live <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!cs_act) begin
      state   <= PS_CMD;
      tx_byte <= '0;
      wr_live <= 1'b0;
    end else if (rx_valid) begin
      tx_byte <= '0;
      if (state == PS_CMD) begin
        if (rx_byte == OP_PIX) begin
          if (pix_valid) begin
            pix_pop <= 1'b1;
            tx_byte <= pix_data;
          end
        end else if (rx_byte == OP_SCAN) begin
          scan_start <= chip_en;
        end else if (rx_byte == OP_STAT) begin
          tx_byte <= status_byte;
        end else if (rx_byte == OP_SRST) begin
          soft_rst <= 1'b1;
        end else if (rx_byte[7:5] == GRP_RD) begin
          if (idx_ok) tx_byte <= rd_data;
        end else if (rx_byte[7:5] == GRP_WR) begin
          state   <= PS_WRITE;
          wr_ptr  <= AW'(idx);
          wr_live <= idx_ok;
        end
      end else if (wr_live) begin
        wr_en   <= 1'b1;
        wr_addr <= wr_ptr;
        wr_data <= rx_byte;
        if (wr_ptr == TOP_ADDR) wr_live <= 1'b0;
        else                    wr_ptr  <= wr_ptr + 1'b1;
      end
    end
  end

  a_r12_cs_drop_resets: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (state == PS_CMD) && (tx_byte == '0));
  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    pix_pop |-> $past(pix_valid));
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < NUM_REGS));
  a_r6_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pix_pop, scan_start, soft_rst, wr_en}));
endmodule

// File: rtl/fp_spi_cmd_core.sv
module fp_spi_cmd_core #(
  parameter int         DW          = 8,
  parameter int         NUM_REGS    = 18,
  parameter int         SYNC_STAGES = 2,
  parameter int         MODE_REG    = 16,
  parameter int         KEY_REG     = 17,
  parameter logic [7:0] MODE_RST    = 8'h40,
  parameter int         KEY_W       = 5,
  parameter logic [4:0] KEY_VAL     = 5'h15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_csn,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_valid,
  output logic          pix_pop,
  input  logic          scan_busy,
  input  logic          finger_hit,
  output logic          scan_start,
  output logic          core_rst,
  output logic          det_en,
  output logic          intr_en
);
  localparam int AW = $clog2(NUM_REGS);

  logic sck_rise, sck_fall, cs_act, cs_start, mosi_s;
  logic [DW-1:0] tx_byte, rx_byte, rd_data, wr_data, status_byte;
  logic rx_valid, wr_en, soft_rst, det_bit, intr_bit, key_ok;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [KEY_W-1:0] key_field;

  fp_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_start(cs_start), .mosi_s(mosi_s)
  );

  fp_spi_byte_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .cs_start(cs_start), .mosi_s(mosi_s), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .miso(spi_miso)
  );

  fp_reg_bank #(
    .DW(DW), .NUM_REGS(NUM_REGS), .MODE_REG(MODE_REG), .KEY_REG(KEY_REG),
    .MODE_RST(MODE_RST), .KEY_W(KEY_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .det_bit(det_bit),
    .intr_bit(intr_bit), .key_field(key_field)
  );

  assign key_ok      = (key_field == KEY_W'(KEY_VAL));
  assign status_byte = DW'({key_ok, finger_hit, scan_busy, pix_valid});

  fp_cmd_parser #(.DW(DW), .NUM_REGS(NUM_REGS)) u_parser (
    .clk(clk), .rst(rst), .cs_act(cs_act), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_data(rd_data), .pix_data(pix_data),
    .pix_valid(pix_valid), .status_byte(status_byte), .chip_en(key_ok),
    .tx_byte(tx_byte), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_pop(pix_pop), .scan_start(scan_start),
    .soft_rst(soft_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst <= 1'b1;
      det_en   <= 1'b0;
      intr_en  <= 1'b0;
    end else begin
      core_rst <= soft_rst | ~key_ok;
      det_en   <= det_bit;
      intr_en  <= intr_bit;
    end
  end

  a_r9_no_key_holds_reset: assert property (@(posedge clk) disable iff (rst)
    !key_ok |=> core_rst);
  a_r8_soft_reset_pulses: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> core_rst);
  a_r6_scan_needs_key: assert property (@(posedge clk) disable iff (rst)
    scan_start |-> $past(key_ok));
endmodule

// File: tb/fp_spi_cmd_core_bench.sv
`timescale 1ns/1ps
module fp_spi_cmd_core_bench;
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, pix_pop, scan_start, core_rst, det_en, intr_en;
  logic [7:0] pix_data;
  logic pix_valid;
  logic scan_busy = 1'b0, finger_hit = 1'b0;

  always #2 clk = ~clk;

  fp_spi_cmd_core u_fp_spi_cmd_core (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_pop(pix_pop), .scan_busy(scan_busy),
    .finger_hit(finger_hit), .scan_start(scan_start), .core_rst(core_rst),
    .det_en(det_en), .intr_en(intr_en)
  );

  int checks = 0, fails = 0;
  logic [7:0] pix_q[$];
  int pix_idx = 0;
  always_comb begin
    pix_valid = (pix_idx < pix_q.size());
    pix_data  = pix_valid ? pix_q[pix_idx] : 8'h00;
  end

  // behavioural model
  int m_regs[18];
  int m_pix = 0;
  bit m_wr, m_live;
  int m_ptr, m_pend;
  int exp_scan, exp_pop, exp_srst;
  int act_scan, act_pop, act_rsthi;
  bit in_xfer = 1'b1, mon_on = 1'b0;
  int idle_cnt = 0;
  logic [7:0] bq[$];

  function automatic bit m_key();
    return (m_regs[17] & 'h1F) == 'h15;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (pix_pop) pix_idx <= pix_idx + 1;
    if (scan_start) act_scan++;
    if (pix_pop) act_pop++;
    if (core_rst) act_rsthi++;
  end

  // per-clock comparison of level outputs against the model (R9, R10)
  always @(negedge clk) begin
    if (!mon_on || in_xfer) idle_cnt = 0;
    else idle_cnt++;
    if (idle_cnt > 6) begin
      chk("R10 det_en", int'(det_en), (m_regs[16] >> 5) & 1);
      chk("R10 intr_en", int'(intr_en), (m_regs[17] >> 6) & 1);
      chk("R9 core_rst", int'(core_rst), int'(!m_key()));
    end
  end

  function automatic void m_step(int b);
    if (m_wr) begin
      m_pend = 0;
      if (m_live) begin
        m_regs[m_ptr] = b;
        if (m_ptr == 17) m_live = 0; else m_ptr++;
      end
      return;
    end
    m_pend = 0;
    if (b == 'h01) begin
      if (m_pix < pix_q.size()) begin m_pend = pix_q[m_pix]; m_pix++; exp_pop++; end
    end else if (b == 'h02) begin
      if (m_key()) exp_scan++;
    end else if (b == 'h03) begin
      m_pend = {m_key(), finger_hit, scan_busy, m_pix < pix_q.size()};
    end else if (b == 'hC0) begin
      exp_srst++;
    end else if ((b >> 5) == 1) begin
      if ((b & 'h1F) < 18) m_pend = m_regs[b & 'h1F];
    end else if ((b >> 5) == 2) begin
      m_wr = 1; m_ptr = b & 'h1F; m_live = (m_ptr < 18);
    end
  endfunction

  task automatic xfer(string req);
    logic [7:0] got;
    in_xfer = 1;
    act_scan = 0; act_pop = 0; act_rsthi = 0;
    exp_scan = 0; exp_pop = 0; exp_srst = 0;
    m_pend = 0; m_wr = 0; m_live = 0;
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    foreach (bq[k]) begin
      int exp;
      exp = m_pend;
      got = '0;
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = bq[k][i];
        repeat (HALF) @(negedge clk);
        got[i] = spi_miso;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sck = 1'b0;
      end
      chk($sformatf("%s miso byte %0d", req, k), int'(got), exp);
      m_step(int'(bq[k]));
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (10) @(negedge clk);
    in_xfer = 0;
    chk({req, " scan_start count (R6)"}, act_scan, exp_scan);
    chk({req, " pix_pop count (R5)"}, act_pop, exp_pop);
    bq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 18; i++) m_regs[i] = (i == 16) ? 'h40 : 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 core_rst", int'(core_rst), 1);
    chk("R1 det_en", int'(det_en), 0);
    chk("R1 intr_en", int'(intr_en), 0);
    chk("R1 miso", int'(spi_miso), 0);
    chk("R1 strobes", int'({scan_start, pix_pop}), 0);
    mon_on = 1'b1;

    // R1 R3 R2: reset values read back, first byte 0
    bq = '{8'h30, 8'h20, 8'h31, 8'h00}; xfer("R3");

    // R9 R10: write key 0x55 to reg 0x11
    bq = '{8'h51, 8'h55}; xfer("R4");
    chk("R9 core released", int'(core_rst), 0);
    chk("R10 intr_en set", int'(intr_en), 1);

    // R4 streaming write past the last register
    bq = '{8'h4F, 8'hA1, 8'h60, 8'h55, 8'h77, 8'h99}; xfer("R4");
    bq = '{8'h2F, 8'h30, 8'h31, 8'h00}; xfer("R4");
    chk("R10 det_en set", int'(det_en), 1);

    // R5 R7 R6 chained commands
    pix_q = '{8'h11, 8'h22, 8'h33};
    scan_busy = 1'b1;
    bq = '{8'h01, 8'h01, 8'h03, 8'h02, 8'h00}; xfer("R5");
    // R5 drain to empty
    bq = '{8'h01, 8'h01, 8'h01, 8'h00}; xfer("R5");
    scan_busy = 1'b0; finger_hit = 1'b1;
    bq = '{8'h03, 8'h00}; xfer("R7");

    // R11 undefined codes
    bq = '{8'h7E, 8'h35, 8'h04, 8'hFF, 8'h00}; xfer("R11");
    bq = '{8'h55, 8'hFF, 8'hFF}; xfer("R4");

    // R12 select drop abandons write and pending data
    bq = '{8'h40, 8'h12}; xfer("R12");
    bq = '{8'h20, 8'h00}; xfer("R12");
    bq = '{8'h31}; xfer("R12");
    bq = '{8'h00}; xfer("R12");

    // R8 soft reset
    bq = '{8'hC0, 8'h00}; xfer("R8");
    chk("R8 one-clock pulse", act_rsthi, 1);
    chk("R8 srst seen", exp_srst, 1);
    bq = '{8'h31, 8'h30, 8'h00}; xfer("R8");

    // R9 R6 R7 with key removed
    bq = '{8'h51, 8'h00}; xfer("R9");
    chk("R9 core held", int'(core_rst), 1);
    bq = '{8'h02, 8'h03, 8'h00}; xfer("R6");

    // R3 R4 full register dump
    for (int a = 0; a < 18; a++) bq.push_back(8'(8'h20 + a));
    bq.push_back(8'h00);
    xfer("R3");

    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule